// File: doc/BRIEF.md
# GPIO Port Edge Interrupt Unit

This unit holds the interrupt side of one eight-pin general-purpose I/O port. Each pin arrives already synchronised to the block clock. The unit compares the level of each pin with its level in the previous cycle, so a pin can trigger on either a rising or a falling transition. A per-pin select bit picks the direction. A detected transition sets a sticky event bit. The port's single interrupt line is raised, one register stage later, while any pending event has its enable bit set.

Software sees four byte-wide registers on a simple register interface:

| Offset | Register | Behaviour |
|---|---|---|
| 0x14 | Event | Pending events; write-one-to-clear |
| 0x18 | Enable | Per-pin interrupt mask |
| 0x1C | Force | Test register; injects events |
| 0x20 | Edge-select | Per-pin trigger direction |

A pin can watch only one direction at a time. To catch both directions, software flips that pin's select bit after each event. The force register is a test aid: each set bit keeps its event bit asserted until the force bit is written back to zero.

Top module: `gpio_edge_irq_port`

## Requirements
- R1: After a synchronous active-low reset, the event, enable, force and edge-select registers all read 0 and `irq` is 0.
- R2: With a pin's edge-select bit at 1, a 0-to-1 transition of that pin sets its event bit at the clock edge where the new level is first sampled.
- R3: With a pin's edge-select bit at 0, a 1-to-0 transition of that pin sets its event bit at the clock edge where the new level is first sampled.
- R4: A transition in the direction that the edge-select bit does not pick leaves the event bit unchanged.
- R5: An event bit latches on its selected transition even when the pin's enable bit is 0.
- R6: Writing the event register (offset 0x14) clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R7: When a selected transition and a clearing write hit the same event bit in the same cycle, the bit stays set.
- R8: `irq` equals the OR over all pins of (event AND enable), delayed by one clock cycle.
- R9: While a force bit (offset 0x1C) is 1, its event bit is set every cycle and a clearing write cannot clear it. After the force bit is written to 0, the event bit can be cleared.
- R10: Changing a pin's edge-select bit (offset 0x20) while the pin level is steady creates no event.
- R11: Enable (0x18), force (0x1C) and edge-select (0x20) read back the value last written. Any address other than the four register offsets reads 0, and writes to such an address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 8 | Synchronised pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write offset |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read offset |
| rd_data | output | 8 | Register read data (combinational) |
| irq | output | 1 | Registered port interrupt |

## Verification
The assertions assume that `pin_in` is already synchronous to `clk`, so each level change lasts at least one full cycle. They also assume that a write strobe carries one address and one data byte for exactly one cycle. The bench changes pins and write strobes only on the falling clock edge and holds each value for at least one whole cycle. Because of this, every transition is seen by exactly one rising edge. The bench also lines up pin changes with clearing writes in the same cycle, on purpose, to check which one takes priority.

// File: rtl/gpio_irq_pkg.sv
// Package: shared register offsets and decode type for the port
// interrupt unit. Offsets are byte addresses within one port window.
package gpio_irq_pkg;

    localparam int unsigned DEF_PINS   = 8;
    localparam int unsigned DEF_ADDR_W = 8;

    localparam logic [7:0] OFS_EVENT = 8'h14;
    localparam logic [7:0] OFS_MASK  = 8'h18;
    localparam logic [7:0] OFS_FORCE = 8'h1C;
    localparam logic [7:0] OFS_EDGE  = 8'h20;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_EVENT,
        REG_MASK,
        REG_FORCE,
        REG_EDGE
    } reg_sel_e;

    // Map a port-relative byte offset onto the register it selects.
    function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
        case (ofs)
            OFS_EVENT: return REG_EVENT;
            OFS_MASK:  return REG_MASK;
            OFS_FORCE: return REG_FORCE;
            OFS_EDGE:  return REG_EDGE;
            default:   return REG_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_irq_edge.sv
// Edge detector: one previous-level flop per pin. A pin hits when its
// current level differs from the previous one in the direction its
// select bit names (1 = rising, 0 = falling).
// Assumes pins are synchronous to clk. During reset the previous-level
// flops track the pins, so a pin that is already high when reset ends
// does not produce a false edge.
module gpio_irq_edge #(
    parameter int unsigned PINS = gpio_irq_pkg::DEF_PINS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_in,
    input  logic [PINS-1:0] edge_sel,
    output logic [PINS-1:0] edge_hit
);

    logic [PINS-1:0] pin_prev;

    // Remember last cycle's level (and follow the pins during reset).
    always_ff @(posedge clk) begin
        pin_prev <= pin_in;
    end

    for (genvar g = 0; g < PINS; g++) begin : g_pin
        logic rise;
        logic fall;
        // Per-pin direction decode.
        always_comb begin
            rise        = pin_in[g] & ~pin_prev[g];
            fall        = ~pin_in[g] & pin_prev[g];
            edge_hit[g] = rst_n & (edge_sel[g] ? rise : fall);
        end
    end

    // R10: a steady pin never reports a hit, whatever its select bit does.
    p_steady_no_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (pin_in == $past(pin_in)) |-> (edge_hit == '0));

endmodule

// File: rtl/gpio_irq_regs.sv
// Register block: decodes writes for the enable, force and edge-select
// registers and produces the clear mask for the event register. Its read
// mux is combinational. Assumes a single-cycle write strobe.
module gpio_irq_regs #(
    parameter int unsigned PINS   = gpio_irq_pkg::DEF_PINS,
    parameter int unsigned ADDR_W = gpio_irq_pkg::DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PINS-1:0]   wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [PINS-1:0]   event_q,
    output logic [PINS-1:0]   mask_q,
    output logic [PINS-1:0]   force_q,
    output logic [PINS-1:0]   edge_q,
    output logic [PINS-1:0]   clr_mask,
    output logic [PINS-1:0]   rd_data
);
    import gpio_irq_pkg::*;

    localparam int unsigned OFS_W = 8;

    reg_sel_e wr_sel;
    reg_sel_e rd_sel;
    logic [OFS_W-1:0] wr_ofs;
    logic [OFS_W-1:0] rd_ofs;

    // Widen or trim the address buses to the offset width.
    always_comb begin
        wr_ofs = OFS_W'(wr_addr);
        rd_ofs = OFS_W'(rd_addr);
        wr_sel = wr_en ? decode_ofs(wr_ofs) : REG_NONE;
        rd_sel = decode_ofs(rd_ofs);
    end

    // Hold the software-written configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            force_q <= '0;
            edge_q  <= '0;
        end else begin
            case (wr_sel)
                REG_MASK:  mask_q  <= wr_data;
                REG_FORCE: force_q <= wr_data;
                REG_EDGE:  edge_q  <= wr_data;
                default:   ;
            endcase
        end
    end

    // Ones written to the event offset become clear requests.
    always_comb begin
        clr_mask = (wr_sel == REG_EVENT) ? wr_data : '0;
    end

    // Read mux; unmapped offsets return zero.
    always_comb begin
        case (rd_sel)
            REG_EVENT: rd_data = event_q;
            REG_MASK:  rd_data = mask_q;
            REG_FORCE: rd_data = force_q;
            REG_EDGE:  rd_data = edge_q;
            default:   rd_data = '0;
        endcase
    end

    // R11: a write to an unmapped offset leaves configuration untouched.
    p_unmapped_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wr_en) && ($past(decode_ofs(wr_ofs)) == REG_NONE)
        |-> $stable(mask_q) && $stable(force_q) && $stable(edge_q));

endmodule

// File: rtl/gpio_irq_events.sv
// Event register: sticky per-pin pending bits. Set sources (edge hit,
// force) take priority over the write-one-to-clear mask.
// Assumes edge_hit and clr_mask are single-cycle qualified pulses.
module gpio_irq_events #(
    parameter int unsigned PINS = gpio_irq_pkg::DEF_PINS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] edge_hit,
    input  logic [PINS-1:0] force_q,
    input  logic [PINS-1:0] clr_mask,
    output logic [PINS-1:0] event_q
);

    logic [PINS-1:0] set_mask;

    // Merge the two set sources.
    always_comb begin
        set_mask = edge_hit | force_q;
    end

    // Latch events; setting wins over clearing in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            event_q <= '0;
        end else begin
            event_q <= (event_q & ~clr_mask) | set_mask;
        end
    end

    // R2 R3 R7: every detected edge is pending next cycle, even against a clear.
    p_edge_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((event_q & $past(edge_hit)) == $past(edge_hit)));

    // R9: forced bits are always pending one cycle later.
    p_force_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((event_q & $past(force_q)) == $past(force_q)));

    // R6: with no set or clear activity the register holds.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(edge_hit) == '0) && ($past(force_q) == '0)
        && ($past(clr_mask) == '0) |-> $stable(event_q));

    // R6: a cleared bit with no set source is low next cycle.
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((event_q & $past(clr_mask & ~edge_hit & ~force_q)) == '0));

endmodule

// File: rtl/gpio_edge_irq_port.sv
// Top of the per-port edge interrupt unit: edge detector, register
// block, event register and the registered interrupt output.
// Assumes pin_in is already synchronised to clk.
module gpio_edge_irq_port #(
    parameter int unsigned PINS   = gpio_irq_pkg::DEF_PINS,
    parameter int unsigned ADDR_W = gpio_irq_pkg::DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PINS-1:0]   pin_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PINS-1:0]   wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [PINS-1:0]   rd_data,
    output logic              irq
);

    logic [PINS-1:0] edge_hit;
    logic [PINS-1:0] event_q;
    logic [PINS-1:0] mask_q;
    logic [PINS-1:0] force_q;
    logic [PINS-1:0] edge_q;
    logic [PINS-1:0] clr_mask;
    logic            irq_next;

    gpio_irq_edge #(.PINS(PINS)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .edge_sel (edge_q),
        .edge_hit (edge_hit)
    );

    gpio_irq_regs #(.PINS(PINS), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .event_q  (event_q),
        .mask_q   (mask_q),
        .force_q  (force_q),
        .edge_q   (edge_q),
        .clr_mask (clr_mask),
        .rd_data  (rd_data)
    );

    gpio_irq_events #(.PINS(PINS)) u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_hit (edge_hit),
        .force_q  (force_q),
        .clr_mask (clr_mask),
        .event_q  (event_q)
    );

    // Reduce masked pending events to one request.
    always_comb begin
        irq_next = |(event_q & mask_q);
    end

    // Register the port interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= irq_next;
    end

    // R8: with every pin masked last cycle the line is low.
    p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(mask_q) == '0) |-> !irq);

    // R8: nothing pending last cycle means no interrupt now.
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(event_q) == '0) |-> !irq);

endmodule

// File: tb/gpio_edge_irq_port_bench.sv
module gpio_edge_irq_port_bench;

    localparam logic [7:0] A_EVT = 8'h14;
    localparam logic [7:0] A_EN  = 8'h18;
    localparam logic [7:0] A_FRC = 8'h1C;
    localparam logic [7:0] A_SEL = 8'h20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_in = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    gpio_edge_irq_port u_gpio_edge_irq_port (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(A_EVT, v); chk("R1 event", v, 8'h00);
        rd(A_EN,  v); chk("R1 enable", v, 8'h00);
        rd(A_FRC, v); chk("R1 force", v, 8'h00);
        rd(A_SEL, v); chk("R1 select", v, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_rising();
        logic [7:0] v;
        wr(A_SEL, 8'hFF);
        pin_in[0] = 1'b1;
        step();
        rd(A_EVT, v); chk("R2 R5 rising sets event with enable 0", v, 8'h01);
        step();
        chk("R8 irq masked", {7'd0, irq}, 8'h00);
        pin_in[0] = 1'b0;
        step();
        rd(A_EVT, v); chk("R4 falling ignored with select 1", v, 8'h01);
        wr(A_EVT, 8'h01);
        rd(A_EVT, v); chk("R6 clear by one", v, 8'h00);
    endtask

    task automatic t_falling();
        logic [7:0] v;
        wr(A_SEL, 8'h00);
        pin_in[1] = 1'b1;
        step();
        rd(A_EVT, v); chk("R4 rising ignored with select 0", v, 8'h00);
        pin_in[1] = 1'b0;
        step();
        rd(A_EVT, v); chk("R3 falling sets event", v, 8'h02);
        wr(A_EVT, 8'hFD);
        rd(A_EVT, v); chk("R6 zero bits keep event", v, 8'h02);
        wr(A_EVT, 8'h02);
        rd(A_EVT, v); chk("R6 clear", v, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        wr(A_SEL, 8'hFF);
        wr(A_EN, 8'h04);
        pin_in[2] = 1'b1;
        step();
        rd(A_EVT, v); chk("R2 event bit2", v, 8'h04);
        chk("R8 irq not yet", {7'd0, irq}, 8'h00);
        step();
        chk("R8 irq raised", {7'd0, irq}, 8'h01);
        wr(A_EN, 8'h00);
        chk("R8 irq lags mask", {7'd0, irq}, 8'h01);
        step();
        chk("R8 irq dropped", {7'd0, irq}, 8'h00);
        wr(A_EVT, 8'h04);
        pin_in[2] = 1'b0;
        step();
    endtask

    task automatic t_collide();
        logic [7:0] v;
        pin_in[3] = 1'b1;
        step();
        pin_in[3] = 1'b0;
        step();
        rd(A_EVT, v); chk("R2 bit3 pending", v, 8'h08);
        pin_in[3] = 1'b1;
        wr(A_EVT, 8'h08);
        rd(A_EVT, v); chk("R7 edge beats clear", v, 8'h08);
        wr(A_EVT, 8'h08);
        rd(A_EVT, v); chk("R7 later clear works", v, 8'h00);
        pin_in[3] = 1'b0;
        step();
    endtask

    task automatic t_sel_change();
        logic [7:0] v;
        wr(A_SEL, 8'h00);
        pin_in[4] = 1'b1;
        step();
        wr(A_EVT, 8'hFF);
        wr(A_SEL, 8'h10);
        step(); step();
        rd(A_EVT, v); chk("R10 select flip high level", v, 8'h00);
        wr(A_SEL, 8'h00);
        step(); step();
        rd(A_EVT, v); chk("R10 select flip back", v, 8'h00);
        pin_in[4] = 1'b0;
        step();
        rd(A_EVT, v); chk("R3 falling after flip", v, 8'h10);
        wr(A_EVT, 8'h10);
    endtask

    task automatic t_force();
        logic [7:0] v;
        wr(A_FRC, 8'h20);
        rd(A_FRC, v); chk("R11 force readback", v, 8'h20);
        step();
        rd(A_EVT, v); chk("R9 force sets event", v, 8'h20);
        wr(A_EVT, 8'h20);
        rd(A_EVT, v); chk("R9 clear blocked while forced", v, 8'h20);
        wr(A_FRC, 8'h00);
        wr(A_EVT, 8'h20);
        rd(A_EVT, v); chk("R9 clear after force off", v, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr(A_EN, 8'hA5);
        rd(A_EN, v); chk("R11 enable readback", v, 8'hA5);
        wr(A_SEL, 8'h3C);
        rd(A_SEL, v); chk("R11 select readback", v, 8'h3C);
        wr(8'h10, 8'hFF);
        wr(8'h24, 8'hFF);
        rd(8'h10, v); chk("R11 unmapped reads zero", v, 8'h00);
        rd(A_EN, v);  chk("R11 enable untouched", v, 8'hA5);
        rd(A_SEL, v); chk("R11 select untouched", v, 8'h3C);
        rd(A_FRC, v); chk("R11 force untouched", v, 8'h00);
        rd(A_EVT, v); chk("R11 event untouched", v, 8'h00);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_rising();
        t_falling();
        t_irq();
        t_collide();
        t_sel_change();
        t_force();
        t_regs();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule